// File: doc/BRIEF.md
# Byte-Wide Serial Controller Register Front End

This block is the host-facing register file of a classic single-channel serial controller. A host issues single-byte accesses into an eight-byte window. The block keeps the line-control, modem-control, interrupt-enable and 16-bit baud divisor settings. It reports line status and the pending interrupt cause. Transmit bytes go out as a one-cycle valid strobe. Received bytes are taken from a holding source that flags when a byte is waiting. Bit framing, baud generation and FIFOs live elsewhere. The divisor value and the control registers are exported for the neighbouring logic.

Interrupts are not raised at once. A transmit-empty or receive-data event starts a per-cause delay timer of `IRQ_DELAY` clock cycles. When the timer runs out, the interrupt line rises and the cause is latched, provided its enable bit is still set. Each timer is a two-state machine:
- `TMR_IDLE` goes to `TMR_COUNT` on *start*.
- `TMR_COUNT` returns to `TMR_IDLE` on *expire* (the count reaches zero) or on *cancel*.
- `TMR_COUNT` goes back to `TMR_COUNT` with a fresh count on *restart* (a start while the timer is running).

Top module: `uart_regfront`

## Requirements
- R1: With line-control bit 7 clear, offset 0 is the data port and offset 1 is the interrupt-enable register. With bit 7 set, offsets 0 and 1 read and write the low and high divisor bytes. The `divisor` output equals {high, low}.
- R2: Line control (offset 3) and modem control (offset 4) read back the last byte written and appear on `line_ctrl` and `modem_ctrl`. Offset 6 reads 0x00.
- R3: Offset 2 reads the interrupt identification byte. A write to offset 2 changes no state.
- R4: Offset 5 reads 0x60 when no received byte is waiting and 0x61 when one is waiting. Bit 0 is data-ready, and bits 5 and 6 are the transmit-empty flags, always set.
- R5: Offset 7 always reads 0x00, and writes to it are discarded.
- R6: A data-port write drives `tx_valid` high for the single cycle after the access edge, with `tx_byte` equal to the written byte. The same write drops `irq`. If interrupt-enable bit 1 (transmit-empty) is set, `irq` rises `IRQ_DELAY` cycles after the access edge.
- R7: An interrupt-enable write stores bits 3:0; bits 7:4 read as 0.
  - If bit 1 is set, a transmit timer starts. If bit 1 is clear, the transmit timer is cancelled and the transmit cause is cleared.
  - If bit 0 is set and a byte is waiting, a receive timer starts. If bit 0 is clear, the receive timer is cancelled and the receive cause is cleared.
  - If either bit is clear, `irq` drops.
- R8: A data-port read while a byte is waiting pulses `rx_pop` in that cycle, returns `rx_byte`, drops `irq` and clears the receive cause. If another byte is waiting on the next cycle and bit 0 is enabled, a receive timer starts then, so `irq` rises `IRQ_DELAY`+1 cycles after the read edge. A read with nothing waiting returns 0x00 and does not pulse `rx_pop`.
- R9: Once raised, `irq` stays high until one of the R6–R8 events drops it; identification reads leave it alone. Every rise of `irq` comes with a latched cause.
- R10: Identification reads 0x04 while a receive cause is latched, otherwise 0x02 while a transmit cause is latched, otherwise 0x01. A read that returns 0x02 clears the transmit cause.
- R11: Starting a timer that is already counting reloads it, so its expiry moves to `IRQ_DELAY` cycles after the latest start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Single-byte access in this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_ofs | input | 3 | Register offset in the window |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte (same cycle as the access) |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| rx_avail | input | 1 | A received byte is waiting |
| rx_byte | input | 8 | The waiting received byte |
| rx_pop | output | 1 | Consume the waiting byte at this edge |
| irq | output | 1 | Interrupt request |
| line_ctrl | output | 8 | Line-control setting |
| modem_ctrl | output | 8 | Modem-control setting |
| divisor | output | 16 | Baud divisor |

## Verification
Read data and `rx_pop` are combinational in the access cycle. The bench samples them 1 ns after it drives the access and before the clock edge. Register effects and `tx_valid` belong to the access edge, so they are checked half a cycle after it. An interrupt from a write is due exactly `IRQ_DELAY` edges after the access edge. An interrupt re-armed by a data read is due one edge later, because the re-check waits a cycle for the source to refill. The bench therefore samples `irq` half a cycle before and half a cycle after each due edge. Rescheduling and cancellation are proved the same way: the check falls in the window where the unmoved timer would already have fired.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned OFS_W      = 3;
    localparam int unsigned IER_W      = 4;
    localparam int unsigned NUM_CAUSES = 2;

    // Cause index equals its enable bit position in the interrupt-enable register
    localparam int unsigned CAUSE_RX = 0;
    localparam int unsigned CAUSE_TX = 1;
    localparam int unsigned DLAB_BIT = 7;

    localparam logic [BYTE_W-1:0] IID_NONE = 8'h01;
    localparam logic [BYTE_W-1:0] IID_TX   = 8'h02;
    localparam logic [BYTE_W-1:0] IID_RX   = 8'h04;
    localparam logic [BYTE_W-1:0] LSR_BASE = 8'h60;

    typedef enum logic [OFS_W-1:0] {
        OFS_DATA = 3'd0,
        OFS_IEN  = 3'd1,
        OFS_IID  = 3'd2,
        OFS_LCTL = 3'd3,
        OFS_MCTL = 3'd4,
        OFS_LSTS = 3'd5,
        OFS_MSTS = 3'd6,
        OFS_SCR  = 3'd7
    } reg_ofs_e;

    typedef enum logic [3:0] {
        RD_ZERO, RD_RXDATA, RD_IEN, RD_DIVLO, RD_DIVHI,
        RD_IID, RD_LCTL, RD_MCTL, RD_LSTS
    } rd_sel_e;

    typedef enum logic {
        TMR_IDLE,
        TMR_COUNT
    } tmr_state_e;

    typedef struct packed {
        logic wr_tx;
        logic rd_rx;
        logic wr_ien;
        logic wr_divlo;
        logic wr_divhi;
        logic wr_lctl;
        logic wr_mctl;
        logic rd_iid;
    } bus_op_t;

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
    import uart_rf_pkg::*;
(
    input  logic             acc_en,
    input  logic             acc_wr,
    input  logic [OFS_W-1:0] acc_ofs,
    input  logic             dlab,
    output bus_op_t          op,
    output rd_sel_e          rd_sel
);

    always_comb begin
        op     = '0;
        rd_sel = RD_ZERO;
        if (acc_en) begin
            unique case (reg_ofs_e'(acc_ofs))
                OFS_DATA: begin
                    if (dlab) begin
                        op.wr_divlo = acc_wr;
                        rd_sel      = RD_DIVLO;
                    end else begin
                        op.wr_tx = acc_wr;
                        op.rd_rx = !acc_wr;
                        rd_sel   = RD_RXDATA;
                    end
                end
                OFS_IEN: begin
                    if (dlab) begin
                        op.wr_divhi = acc_wr;
                        rd_sel      = RD_DIVHI;
                    end else begin
                        op.wr_ien = acc_wr;
                        rd_sel    = RD_IEN;
                    end
                end
                OFS_IID: begin
                    // a write here would be a FIFO control: swallowed
                    op.rd_iid = !acc_wr;
                    rd_sel    = RD_IID;
                end
                OFS_LCTL: begin
                    op.wr_lctl = acc_wr;
                    rd_sel     = RD_LCTL;
                end
                OFS_MCTL: begin
                    op.wr_mctl = acc_wr;
                    rd_sel     = RD_MCTL;
                end
                OFS_LSTS: rd_sel = RD_LSTS;
                OFS_MSTS: rd_sel = RD_ZERO;
                OFS_SCR:  rd_sel = RD_ZERO;
            endcase
        end
    end

endmodule

// File: rtl/uart_rf_delay.sv
module uart_rf_delay
    import uart_rf_pkg::*;
#(
    parameter int unsigned DELAY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    output logic expire
);

    localparam int unsigned CNT_W = $clog2(DELAY + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(DELAY - 1);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TMR_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        unique case (state_q)
            TMR_IDLE: begin
                if (start && !cancel) begin
                    state_d = TMR_COUNT;
                    cnt_d   = LOAD;
                end
            end
            TMR_COUNT: begin
                if (cancel) begin
                    state_d = TMR_IDLE;
                end else if (start) begin
                    cnt_d = LOAD;
                end else if (cnt_q == '0) begin
                    expire  = 1'b1;
                    state_d = TMR_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    // R11: a running count steps down by one each cycle
    p_count_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_COUNT && cnt_q != '0 && !start && !cancel)
        |=> (state_q == TMR_COUNT && cnt_q == $past(cnt_q) - 1'b1));

    // R11: any start reloads the full count
    p_restart_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !cancel) |=> (state_q == TMR_COUNT && cnt_q == LOAD));

    // R7: cancel always returns the timer to idle
    p_cancel_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> state_q == TMR_IDLE);

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_rf_pkg::*;
#(
    parameter int unsigned IRQ_DELAY = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [OFS_W-1:0]  acc_ofs,
    input  logic [BYTE_W-1:0] acc_wdata,
    output logic [BYTE_W-1:0] acc_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              rx_avail,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_pop,
    output logic              irq,
    output logic [BYTE_W-1:0] line_ctrl,
    output logic [BYTE_W-1:0] modem_ctrl,
    output logic [2*BYTE_W-1:0] divisor
);

    logic [BYTE_W-1:0] lctl_q, mctl_q, divlo_q, divhi_q, txb_q;
    logic [IER_W-1:0]  ien_q;
    logic              txv_q, irq_q, recheck_q;
    logic [NUM_CAUSES-1:0] cause_q;

    bus_op_t op;
    rd_sel_e rd_sel;

    logic [NUM_CAUSES-1:0] tmr_start, tmr_cancel, tmr_expire;
    logic [NUM_CAUSES-1:0] tmr_cond, tmr_trig, raise, cause_clr;
    logic                  irq_drop;

    uart_rf_decode u_decode (
        .acc_en (acc_en),
        .acc_wr (acc_wr),
        .acc_ofs(acc_ofs),
        .dlab   (lctl_q[DLAB_BIT]),
        .op     (op),
        .rd_sel (rd_sel)
    );

    // per-cause scheduling inputs
    assign tmr_cond[CAUSE_RX] = rx_avail;
    assign tmr_cond[CAUSE_TX] = 1'b1;
    assign tmr_trig[CAUSE_RX] = recheck_q && rx_avail;
    assign tmr_trig[CAUSE_TX] = op.wr_tx;

    assign cause_clr[CAUSE_RX] = op.rd_rx;
    assign cause_clr[CAUSE_TX] = op.rd_iid && !cause_q[CAUSE_RX];

    for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_cause
        assign tmr_start[g]  = (op.wr_ien && acc_wdata[g] && tmr_cond[g])
                             || (tmr_trig[g] && ien_q[g]);
        assign tmr_cancel[g] = op.wr_ien && !acc_wdata[g];
        assign raise[g]      = tmr_expire[g] && ien_q[g];

        uart_rf_delay #(.DELAY(IRQ_DELAY)) u_delay (
            .clk   (clk),
            .rst_n (rst_n),
            .start (tmr_start[g]),
            .cancel(tmr_cancel[g]),
            .expire(tmr_expire[g])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cause_q[g] <= 1'b0;
            end else if (raise[g]) begin
                cause_q[g] <= 1'b1;
            end else if (cause_clr[g] || tmr_cancel[g]) begin
                cause_q[g] <= 1'b0;
            end
        end
    end

    assign irq_drop = op.wr_tx || op.rd_rx
                    || (op.wr_ien && !(acc_wdata[CAUSE_RX] && acc_wdata[CAUSE_TX]));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (|raise) begin
            irq_q <= 1'b1;
        end else if (irq_drop) begin
            irq_q <= 1'b0;
        end
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lctl_q  <= '0;
            mctl_q  <= '0;
            divlo_q <= '0;
            divhi_q <= '0;
            ien_q   <= '0;
        end else begin
            if (op.wr_lctl)  lctl_q  <= acc_wdata;
            if (op.wr_mctl)  mctl_q  <= acc_wdata;
            if (op.wr_divlo) divlo_q <= acc_wdata;
            if (op.wr_divhi) divhi_q <= acc_wdata;
            if (op.wr_ien)   ien_q   <= acc_wdata[IER_W-1:0];
        end
    end

    // transmit strobe and receive re-check
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txv_q     <= 1'b0;
            txb_q     <= '0;
            recheck_q <= 1'b0;
        end else begin
            txv_q     <= op.wr_tx;
            recheck_q <= op.rd_rx;
            if (op.wr_tx) txb_q <= acc_wdata;
        end
    end

    // read path
    always_comb begin
        unique case (rd_sel)
            RD_RXDATA: acc_rdata = rx_avail ? rx_byte : '0;
            RD_IEN:    acc_rdata = {{(BYTE_W-IER_W){1'b0}}, ien_q};
            RD_DIVLO:  acc_rdata = divlo_q;
            RD_DIVHI:  acc_rdata = divhi_q;
            RD_IID:    acc_rdata = cause_q[CAUSE_RX] ? IID_RX
                                 : (cause_q[CAUSE_TX] ? IID_TX : IID_NONE);
            RD_LCTL:   acc_rdata = lctl_q;
            RD_MCTL:   acc_rdata = mctl_q;
            RD_LSTS:   acc_rdata = LSR_BASE | {{(BYTE_W-1){1'b0}}, rx_avail};
            default:   acc_rdata = '0;
        endcase
    end

    assign rx_pop     = op.rd_rx && rx_avail;
    assign tx_valid   = txv_q;
    assign tx_byte    = txb_q;
    assign irq        = irq_q;
    assign line_ctrl  = lctl_q;
    assign modem_ctrl = mctl_q;
    assign divisor    = {divhi_q, divlo_q};

    // R8: the source is only consumed when it holds a byte
    p_pop_needs_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> rx_avail);

    // R6: data-port write yields a one-cycle strobe with the written byte
    p_tx_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_ofs == 3'd0 && !lctl_q[DLAB_BIT])
        |=> (tx_valid && tx_byte == $past(acc_wdata)));

    // R6: transmit write drops irq unless a cause fires in the same cycle
    p_tx_drops_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_ofs == 3'd0 && !lctl_q[DLAB_BIT] && !(|raise))
        |=> !irq);

    // R9: irq never rises without a latched cause
    p_irq_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (|cause_q));

    // R5: scratch offset reads zero
    p_scratch_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && acc_ofs == 3'd7) |-> acc_rdata == '0);

    // R4: line status carries fixed transmit flags and data-ready
    p_lsts_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && acc_ofs == 3'd5)
        |-> (acc_rdata[6:5] == 2'b11 && acc_rdata[0] == rx_avail));

endmodule

// File: tb/uart_regfront_tb.sv
`timescale 1ns/1ps
module uart_regfront_tb;

    localparam int DLY = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0;
    logic       acc_wr = 1'b0;
    logic [2:0] acc_ofs = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       rx_avail;
    logic [7:0] rx_byte;
    logic       rx_pop;
    logic       irq;
    logic [7:0] line_ctrl, modem_ctrl;
    logic [15:0] divisor;

    int n_chk = 0;
    int n_err = 0;
    int rx_pushed = 0;
    int rx_popped = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign rx_avail = (rx_pushed != rx_popped);
    assign rx_byte  = 8'hA0 + 8'(rx_popped);

    always @(posedge clk) if (rx_pop) rx_popped <= rx_popped + 1;

    uart_regfront #(.IRQ_DELAY(DLY)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_ofs(acc_ofs), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .rx_avail(rx_avail),
        .rx_byte(rx_byte), .rx_pop(rx_pop), .irq(irq),
        .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl), .divisor(divisor)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // callers are positioned at a falling edge; access lands on the next rising edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        acc_en = 1'b1; acc_wr = 1'b1; acc_ofs = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        acc_en = 1'b1; acc_wr = 1'b0; acc_ofs = a;
        #1 d = acc_rdata;
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] v;
        logic [7:0] last_m;
        last_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R9 reset irq", 16'(irq), 16'h0);
        check("R6 reset tx_valid", 16'(tx_valid), 16'h0);
        check("R1 reset divisor", divisor, 16'h0);
        rd(3'd2, d); check("R10 reset iid", 16'(d), 16'h01);
        rd(3'd5, d); check("R4 reset lsts", 16'(d), 16'h60);
        rd(3'd1, d); check("R7 reset ien", 16'(d), 16'h00);

        // R1: divisor overlay sweep
        for (int i = 0; i < 8; i++) begin
            v = 8'((i * 37 + 5) & 8'hFF);
            wr(3'd3, 8'h80);
            wr(3'd0, v);
            wr(3'd1, v ^ 8'hFF);
            rd(3'd0, d); check("R1 divlo", 16'(d), 16'(v));
            rd(3'd1, d); check("R1 divhi", 16'(d), 16'(v ^ 8'hFF));
            check("R1 divisor port", divisor, {v ^ 8'hFF, v});
            check("R1 no tx in overlay", 16'(tx_valid), 16'h0);
            wr(3'd3, 8'h03);
            rd(3'd1, d); check("R1 ien visible", 16'(d), 16'h00);
        end

        // R2: control registers
        for (int i = 0; i < 8; i++) begin
            v = 8'((i * 29 + 3) & 8'hFF);
            wr(3'd4, v);
            rd(3'd4, d); check("R2 mctl", 16'(d), 16'(v));
            check("R2 modem_ctrl", 16'(modem_ctrl), 16'(v));
            last_m = v;
            wr(3'd3, v & 8'h7F);
            rd(3'd3, d); check("R2 lctl", 16'(d), 16'(v & 8'h7F));
            check("R2 line_ctrl", 16'(line_ctrl), 16'(v & 8'h7F));
            rd(3'd6, d); check("R2 msts zero", 16'(d), 16'h0);
        end
        wr(3'd3, 8'h03);

        // R5 / R3
        wr(3'd7, 8'hFF);
        rd(3'd7, d); check("R5 scratch", 16'(d), 16'h0);
        wr(3'd2, 8'hFF);
        rd(3'd2, d); check("R3 iid after write", 16'(d), 16'h01);
        rd(3'd3, d); check("R3 lctl kept", 16'(d), 16'h03);
        rd(3'd4, d); check("R3 mctl kept", 16'(d), 16'(last_m));
        rd(3'd1, d); check("R3 ien kept", 16'(d), 16'h00);

        // R6: transmit without enable
        wr(3'd0, 8'h5A);
        check("R6 tx_valid", 16'(tx_valid), 16'h1);
        check("R6 tx_byte", 16'(tx_byte), 16'h5A);
        wait_cyc(1);
        check("R6 tx_valid one cycle", 16'(tx_valid), 16'h0);
        wait_cyc(DLY + 2);
        check("R6 no irq when disabled", 16'(irq), 16'h0);

        // R7: enable transmit interrupt
        wr(3'd1, 8'hF2);
        wait_cyc(DLY - 1); check("R7 tx irq not early", 16'(irq), 16'h0);
        wait_cyc(1);       check("R7 tx irq due", 16'(irq), 16'h1);
        rd(3'd1, d); check("R7 ien low nibble", 16'(d), 16'h02);
        rd(3'd2, d); check("R10 tx iid", 16'(d), 16'h02);
        rd(3'd2, d); check("R10 tx cause cleared", 16'(d), 16'h01);
        check("R9 irq held over iid read", 16'(irq), 16'h1);
        wr(3'd0, 8'h33);
        check("R6 tx write drops irq", 16'(irq), 16'h0);
        wait_cyc(DLY - 1); check("R6 tx irq not early", 16'(irq), 16'h0);
        wait_cyc(1);       check("R6 tx irq due", 16'(irq), 16'h1);

        // R7: cancel
        wr(3'd1, 8'h00);
        check("R7 disable drops irq", 16'(irq), 16'h0);
        wr(3'd1, 8'h02);
        wait_cyc(2);
        wr(3'd1, 8'h00);
        wait_cyc(DLY + 3);
        check("R7 cancelled timer silent", 16'(irq), 16'h0);

        // R11: restart moves expiry
        wr(3'd1, 8'h02);
        wait_cyc(2);
        wr(3'd0, 8'h77);
        wait_cyc(DLY - 1); check("R11 restart delays irq", 16'(irq), 16'h0);
        wait_cyc(1);       check("R11 irq after restart", 16'(irq), 16'h1);
        wr(3'd1, 8'h00);

        // R8: receive path
        rx_pushed = rx_pushed + 2;
        rd(3'd5, d); check("R4 data ready", 16'(d), 16'h61);
        wr(3'd1, 8'h01);
        wait_cyc(DLY - 1); check("R7 rx irq not early", 16'(irq), 16'h0);
        wait_cyc(1);       check("R7 rx irq due", 16'(irq), 16'h1);
        rd(3'd2, d); check("R10 rx iid", 16'(d), 16'h04);
        rd(3'd0, d); check("R8 first byte", 16'(d), 16'hA0);
        check("R8 read drops irq", 16'(irq), 16'h0);
        check("R8 popped once", 16'(rx_popped), 16'd1);
        wait_cyc(DLY);     check("R8 re-arm not early", 16'(irq), 16'h0);
        wait_cyc(1);       check("R8 re-arm due", 16'(irq), 16'h1);
        rd(3'd0, d); check("R8 second byte", 16'(d), 16'hA1);
        wait_cyc(DLY + 3);
        check("R8 no re-arm when empty", 16'(irq), 16'h0);
        rd(3'd2, d); check("R8 rx cause cleared", 16'(d), 16'h01);
        rd(3'd0, d); check("R8 empty read value", 16'(d), 16'h00);
        wait_cyc(1);
        check("R8 empty read no pop", 16'(rx_popped), 16'd2);
        rd(3'd5, d); check("R4 no data", 16'(d), 16'h60);

        // R10: priority of receive over transmit
        rx_pushed = rx_pushed + 1;
        wr(3'd1, 8'h03);
        wait_cyc(DLY);
        check("R9 both causes irq", 16'(irq), 16'h1);
        rd(3'd2, d); check("R10 rx wins", 16'(d), 16'h04);
        rd(3'd2, d); check("R10 tx kept under rx", 16'(d), 16'h04);
        rd(3'd0, d); check("R8 third byte", 16'(d), 16'hA2);
        rd(3'd2, d); check("R10 tx after rx", 16'(d), 16'h02);
        rd(3'd2, d); check("R10 all clear", 16'(d), 16'h01);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule